// File: doc/BRIEF.md
# Store-and-Replay Transmit Sample Buffer

This block sits on the transmit side of a converter data path. Software first arms it with a request/acknowledge handshake. A streaming source, such as a DMA engine, then fills an internal RAM with one packet of samples that ends on TLAST. When a start event occurs, the block plays the stored samples out to a device-side read port. That port has no back-pressure: the device pulls one word per strobe, whether or not data is ready.

Playback either loops over the stored packet without end or makes one pass and stops. Three start sources can be chosen:
- the end of the packet itself;
- an external hardware trigger;
- a self-clearing software pulse.

While playback runs, the source side is held busy. A clear input returns every counter and the state machine to idle. The current state is visible on an 8-bit status field.

Top module: `tx_replay_buf`

## Requirements
- R1: After reset `state_o` is 0 (idle), and `init_ack`, `s_tready`, `dev_rd_unf` and `dev_rd_data` are all zero.
- R2: A cycle with `init_req` high in idle (0), play (4) or done (5) moves the state to arm (1) for one cycle and then to fill (2). `init_ack` is high exactly while the state is fill (2) or hold (3).
- R3: In fill, `s_tready` is high. Each accepted beat is written to the next RAM word, starting at word 0.
- R4: With `sync_mode` = 0 (automatic), accepting a beat with `s_tlast` high ends the fill, and the state is play (4) on the next cycle.
- R5: With `sync_mode` = 1 (hardware), `hw_trig` in fill or hold starts play. The stored length is the number of beats accepted up to and including the trigger cycle, and later source beats are refused. With modes 1 and 2, a TLAST beat moves the state to hold (3).
- R6: With `sync_mode` = 2 (software), a one-cycle `sw_trig` starts play in the same way. A trigger that belongs to a mode other than the selected one has no effect.
- R7: A hardware or software trigger that arrives while zero beats are stored is ignored, and the state stays in fill.
- R8: When DEPTH beats have been accepted without TLAST, the fill ends as if the last of them carried TLAST.
- R9: `s_tready` is low in every state other than fill, so the source is blocked during hold and play.
- R10: In play, each `dev_rd_valid` strobe presents the next stored word on `dev_rd_data` one cycle later. With `oneshot_en` low, the word after the last stored beat is word 0 again (cyclic).
- R11: With `oneshot_en` high, the strobe that reads the last stored beat moves the state to done (5). Done is left only through `init_req` or `soft_clear`.
- R12: A strobe while the state is not play raises `dev_rd_unf` for the next cycle with `dev_rd_data` zero. `dev_rd_data` is zero in every cycle that does not follow a strobe in play.
- R13: `soft_clear` in any state returns the state to idle (0) on the next cycle and discards the stored length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| soft_clear | input | 1 | Control bit: clear counters and return to idle |
| init_req | input | 1 | Arm request |
| init_ack | output | 1 | Buffer is accepting source data / awaiting start |
| sync_mode | input | 2 | Start source: 0 automatic, 1 hardware, 2 software |
| oneshot_en | input | 1 | 1 = single pass, 0 = cyclic replay |
| hw_trig | input | 1 | External start trigger |
| sw_trig | input | 1 | Self-clearing software start pulse |
| s_tvalid | input | 1 | Source stream valid |
| s_tready | output | 1 | Source stream ready |
| s_tdata | input | DATA_W | Source stream payload |
| s_tlast | input | 1 | Source stream end of packet |
| dev_rd_valid | input | 1 | Device read strobe |
| dev_rd_data | output | DATA_W | Word returned one cycle after a strobe |
| dev_rd_unf | output | 1 | Underflow: strobe with no playback active |
| state_o | output | 8 | Current control state, zero-extended |

## Verification
The hardest condition to reach is a hardware trigger that lands in the same cycle as a source handshake partway through a packet. The cut-off length must then count that beat, and every later source beat must be refused. The bench drives the fourth beat of an unterminated packet together with `hw_trig`. It keeps `s_tvalid` asserted afterwards and observes the truncation through the wrap point of cyclic replay. A sweep over every packet length from 1 to DEPTH, in both cyclic and one-shot form, covers the wrap and stop boundaries.

// File: rtl/tx_replay_pkg.sv
package tx_replay_pkg;
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_ARM  = 3'd1,
        ST_FILL = 3'd2,
        ST_HOLD = 3'd3,
        ST_PLAY = 3'd4,
        ST_DONE = 3'd5
    } rb_state_e;

    typedef enum logic [1:0] {
        SYNC_AUTO = 2'd0,
        SYNC_HW   = 2'd1,
        SYNC_SW   = 2'd2,
        SYNC_NONE = 2'd3
    } rb_sync_e;
endpackage

// File: rtl/tx_replay_ram.sv
module tx_replay_ram #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 16,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/tx_replay_ctrl.sv
module tx_replay_ctrl
    import tx_replay_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_clear,
    input  logic          init_req,
    input  logic [1:0]    sync_mode,
    input  logic          oneshot_en,
    input  logic          hw_trig,
    input  logic          sw_trig,
    input  logic          s_tvalid,
    input  logic          s_tlast,
    input  logic          dev_rd_valid,
    output logic          s_tready,
    output logic          init_ack,
    output logic          wr_en,
    output logic [AW-1:0] waddr,
    output logic [AW-1:0] raddr,
    output logic          playing,
    output logic [7:0]    state_o
);
    typedef struct packed {
        rb_state_e     st;
        logic [CW-1:0] wptr;
        logic [CW-1:0] len;
        logic [CW-1:0] rptr;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{st: ST_IDLE, wptr: '0, len: '0, rptr: '0};

    ctrl_t q, d;
    logic          accept;
    logic          trig;
    logic          end_fill;
    logic [CW-1:0] cnt;

    always_comb begin
        d        = q;
        wr_en    = 1'b0;
        accept   = (q.st == ST_FILL) && s_tvalid;
        trig     = ((rb_sync_e'(sync_mode) == SYNC_HW) && hw_trig) ||
                   ((rb_sync_e'(sync_mode) == SYNC_SW) && sw_trig);
        cnt      = accept ? q.wptr + CW'(1) : q.wptr;
        end_fill = accept && (s_tlast || (cnt == CW'(DEPTH)));

        unique case (q.st)
            ST_IDLE: begin
                if (init_req) d.st = ST_ARM;
            end
            ST_ARM: begin
                d.wptr = '0;
                d.len  = '0;
                d.rptr = '0;
                d.st   = ST_FILL;
            end
            ST_FILL: begin
                if (accept) begin
                    wr_en  = 1'b1;
                    d.wptr = cnt;
                end
                if (trig && (cnt != '0)) begin
                    d.len  = cnt;
                    d.rptr = '0;
                    d.st   = ST_PLAY;
                end else if (end_fill) begin
                    d.len  = cnt;
                    d.rptr = '0;
                    d.st   = (rb_sync_e'(sync_mode) == SYNC_AUTO) ? ST_PLAY : ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (trig) begin
                    d.rptr = '0;
                    d.st   = ST_PLAY;
                end
            end
            ST_PLAY: begin
                if (dev_rd_valid) begin
                    if (q.rptr == q.len - CW'(1)) begin
                        d.rptr = '0;
                        if (oneshot_en) d.st = ST_DONE;
                    end else begin
                        d.rptr = q.rptr + CW'(1);
                    end
                end
                if (init_req) d.st = ST_ARM;
            end
            ST_DONE: begin
                if (init_req) d.st = ST_ARM;
            end
            default: d.st = ST_IDLE;
        endcase

        if (soft_clear) d = CTRL_RST;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= CTRL_RST;
        else        q <= d;
    end

    assign s_tready = (q.st == ST_FILL);
    assign init_ack = (q.st == ST_FILL) || (q.st == ST_HOLD);
    assign waddr    = q.wptr[AW-1:0];
    assign raddr    = q.rptr[AW-1:0];
    assign playing  = (q.st == ST_PLAY);
    assign state_o  = {5'd0, q.st};
endmodule

// File: rtl/tx_replay_rdport.sv
module tx_replay_rdport #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dev_rd_valid,
    input  logic              playing,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic [DATA_W-1:0] dev_rd_data,
    output logic              dev_rd_unf
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              unf;
    } port_t;

    port_t q, d;

    always_comb begin
        d.data = (dev_rd_valid && playing) ? ram_rdata : '0;
        d.unf  = dev_rd_valid && !playing;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign dev_rd_data = q.data;
    assign dev_rd_unf  = q.unf;
endmodule

// File: rtl/tx_replay_buf.sv
module tx_replay_buf #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 16,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_clear,
    input  logic              init_req,
    output logic              init_ack,
    input  logic [1:0]        sync_mode,
    input  logic              oneshot_en,
    input  logic              hw_trig,
    input  logic              sw_trig,
    input  logic              s_tvalid,
    output logic              s_tready,
    input  logic [DATA_W-1:0] s_tdata,
    input  logic              s_tlast,
    input  logic              dev_rd_valid,
    output logic [DATA_W-1:0] dev_rd_data,
    output logic              dev_rd_unf,
    output logic [7:0]        state_o
);
    logic              wr_en;
    logic [AW-1:0]     waddr;
    logic [AW-1:0]     raddr;
    logic              playing;
    logic [DATA_W-1:0] ram_rdata;

    tx_replay_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .soft_clear   (soft_clear),
        .init_req     (init_req),
        .sync_mode    (sync_mode),
        .oneshot_en   (oneshot_en),
        .hw_trig      (hw_trig),
        .sw_trig      (sw_trig),
        .s_tvalid     (s_tvalid),
        .s_tlast      (s_tlast),
        .dev_rd_valid (dev_rd_valid),
        .s_tready     (s_tready),
        .init_ack     (init_ack),
        .wr_en        (wr_en),
        .waddr        (waddr),
        .raddr        (raddr),
        .playing      (playing),
        .state_o      (state_o)
    );

    tx_replay_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ram (
        .clk   (clk),
        .we    (wr_en),
        .waddr (waddr),
        .wdata (s_tdata),
        .raddr (raddr),
        .rdata (ram_rdata)
    );

    tx_replay_rdport #(.DATA_W(DATA_W)) u_rdport (
        .clk          (clk),
        .rst_n        (rst_n),
        .dev_rd_valid (dev_rd_valid),
        .playing      (playing),
        .ram_rdata    (ram_rdata),
        .dev_rd_data  (dev_rd_data),
        .dev_rd_unf   (dev_rd_unf)
    );
endmodule

// File: rtl/tx_replay_chk.sv
module tx_replay_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              soft_clear,
    input logic              init_req,
    input logic              init_ack,
    input logic              s_tready,
    input logic              dev_rd_valid,
    input logic [DATA_W-1:0] dev_rd_data,
    input logic              dev_rd_unf,
    input logic [7:0]        state_o
);
    p_tready_fill_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
        s_tready |-> (state_o == 8'd2));

    p_ack_low_in_play_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 8'd4) |-> !init_ack);

    p_unf_outside_play_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_rd_valid && (state_o != 8'd4)) |=> dev_rd_unf);

    p_quiet_data_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!dev_rd_valid || (state_o != 8'd4)) |=> (dev_rd_data == '0));

    p_clear_to_idle_r13: assert property (@(posedge clk) disable iff (!rst_n)
        soft_clear |=> (state_o == 8'd0));

    p_done_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_o == 8'd5) && !init_req && !soft_clear) |=> (state_o == 8'd5));
endmodule

bind tx_replay_buf tx_replay_chk #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .soft_clear   (soft_clear),
    .init_req     (init_req),
    .init_ack     (init_ack),
    .s_tready     (s_tready),
    .dev_rd_valid (dev_rd_valid),
    .dev_rd_data  (dev_rd_data),
    .dev_rd_unf   (dev_rd_unf),
    .state_o      (state_o)
);

// File: tb/tb_tx_replay_buf.sv
module tb_tx_replay_buf;
    localparam int DW = 16;
    localparam int DP = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          soft_clear = 1'b0;
    logic          init_req = 1'b0;
    logic          init_ack;
    logic [1:0]    sync_mode = 2'd0;
    logic          oneshot_en = 1'b0;
    logic          hw_trig = 1'b0;
    logic          sw_trig = 1'b0;
    logic          s_tvalid = 1'b0;
    logic          s_tready;
    logic [DW-1:0] s_tdata = '0;
    logic          s_tlast = 1'b0;
    logic          dev_rd_valid = 1'b0;
    logic [DW-1:0] dev_rd_data;
    logic          dev_rd_unf;
    logic [7:0]    state_o;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    tx_replay_buf #(.DATA_W(DW), .DEPTH(DP)) dut (
        .clk(clk), .rst_n(rst_n), .soft_clear(soft_clear),
        .init_req(init_req), .init_ack(init_ack),
        .sync_mode(sync_mode), .oneshot_en(oneshot_en),
        .hw_trig(hw_trig), .sw_trig(sw_trig),
        .s_tvalid(s_tvalid), .s_tready(s_tready), .s_tdata(s_tdata), .s_tlast(s_tlast),
        .dev_rd_valid(dev_rd_valid), .dev_rd_data(dev_rd_data),
        .dev_rd_unf(dev_rd_unf), .state_o(state_o)
    );

    function automatic logic [DW-1:0] pat(int tag, int i);
        return 16'((tag << 8) | ((i * 3 + 1) & 8'hFF)) ^ 16'h5A00;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic arm();
        init_req = 1'b1;
        @(negedge clk);
        init_req = 1'b0;
        check("R2 arm state", 32'(state_o), 32'd1);
        check("R2 ack low in arm", 32'(init_ack), 32'd0);
        @(negedge clk);
        check("R2 fill state", 32'(state_o), 32'd2);
        check("R2 ack in fill", 32'(init_ack), 32'd1);
    endtask

    task automatic send(int tag, int n, bit with_last);
        for (int i = 0; i < n; i++) begin
            s_tvalid = 1'b1;
            s_tdata  = pat(tag, i);
            s_tlast  = with_last && (i == n - 1);
            check("R3 tready in fill", 32'(s_tready), 32'd1);
            @(negedge clk);
        end
        s_tvalid = 1'b0;
        s_tlast  = 1'b0;
    endtask

    task automatic read_chk(string req, int tag, int len, int n);
        for (int k = 0; k < n; k++) begin
            dev_rd_valid = 1'b1;
            @(negedge clk);
            check(req, 32'(dev_rd_data), 32'(pat(tag, k % len)));
            check("R12 no unf in play", 32'(dev_rd_unf), 32'd0);
        end
        dev_rd_valid = 1'b0;
    endtask

    task automatic strobe_unf(string req);
        dev_rd_valid = 1'b1;
        @(negedge clk);
        dev_rd_valid = 1'b0;
        check(req, 32'(dev_rd_unf), 32'd1);
        check("R12 zero data on unf", 32'(dev_rd_data), 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 state", 32'(state_o), 32'd0);
        check("R1 ack", 32'(init_ack), 32'd0);
        check("R1 tready", 32'(s_tready), 32'd0);
        check("R1 data", 32'(dev_rd_data), 32'd0);
        check("R1 unf", 32'(dev_rd_unf), 32'd0);
        strobe_unf("R12 unf in idle");

        // R4 R10: automatic cyclic sweep over every length; re-arm from play (R2)
        sync_mode = 2'd0;
        oneshot_en = 1'b0;
        for (int len = 1; len <= DP; len++) begin
            arm();
            send(len, len, 1'b1);
            check("R4 play after tlast", 32'(state_o), 32'd4);
            check("R9 tready low in play", 32'(s_tready), 32'd0);
            read_chk("R10 cyclic data", len, len, 2 * len + 1);
        end

        // R11: one-shot sweep
        oneshot_en = 1'b1;
        for (int len = 1; len <= DP; len++) begin
            arm();
            send(len + 16, len, 1'b1);
            read_chk("R11 one-shot data", len + 16, len, len);
            check("R11 done state", 32'(state_o), 32'd5);
            repeat (2) @(negedge clk);
            check("R11 done holds", 32'(state_o), 32'd5);
            strobe_unf("R12 unf after one-shot");
        end
        oneshot_en = 1'b0;

        // R8: full buffer without tlast
        arm();
        send(40, DP, 1'b0);
        check("R8 full ends fill", 32'(state_o), 32'd4);
        read_chk("R8 full data", 40, DP, DP + 2);

        // R5 R6: hardware trigger with a beat in the same cycle; sw_trig ignored
        sync_mode = 2'd1;
        arm();
        send(50, 2, 1'b0);
        sw_trig = 1'b1;
        s_tvalid = 1'b1; s_tdata = pat(50, 2);
        @(negedge clk);
        sw_trig = 1'b0;
        check("R6 sw_trig ignored in hw mode", 32'(state_o), 32'd2);
        s_tdata = pat(50, 3);
        hw_trig = 1'b1;
        @(negedge clk);
        hw_trig = 1'b0;
        s_tdata = pat(50, 4);
        check("R5 play after hw trig", 32'(state_o), 32'd4);
        check("R9 source blocked", 32'(s_tready), 32'd0);
        check("R2 ack dropped", 32'(init_ack), 32'd0);
        @(negedge clk);
        s_tvalid = 1'b0;
        read_chk("R5 truncated length 4", 50, 4, 9);

        // R5: tlast in hw mode goes to hold
        arm();
        send(55, 3, 1'b1);
        check("R5 hold after tlast", 32'(state_o), 32'd3);
        check("R9 tready low in hold", 32'(s_tready), 32'd0);
        hw_trig = 1'b1;
        @(negedge clk);
        hw_trig = 1'b0;
        read_chk("R5 hold then hw play", 55, 3, 6);

        // R7: zero-length trigger ignored
        sync_mode = 2'd2;
        arm();
        sw_trig = 1'b1;
        @(negedge clk);
        sw_trig = 1'b0;
        check("R7 empty trigger ignored", 32'(state_o), 32'd2);

        // R6: software mode, hold, hw_trig ignored
        send(60, 5, 1'b1);
        check("R6 hold state", 32'(state_o), 32'd3);
        check("R6 ack in hold", 32'(init_ack), 32'd1);
        hw_trig = 1'b1;
        @(negedge clk);
        hw_trig = 1'b0;
        check("R6 hw_trig ignored in sw mode", 32'(state_o), 32'd3);
        sw_trig = 1'b1;
        @(negedge clk);
        sw_trig = 1'b0;
        check("R6 play after sw trig", 32'(state_o), 32'd4);
        read_chk("R6 sw data", 60, 5, 7);

        // R13: soft clear during play
        soft_clear = 1'b1;
        @(negedge clk);
        soft_clear = 1'b0;
        check("R13 idle after clear", 32'(state_o), 32'd0);
        check("R13 ack low", 32'(init_ack), 32'd0);
        strobe_unf("R13 no playback after clear");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule